// File: doc/BRIEF.md
# Write-Through Update Coherence Controller

This block keeps one small direct-mapped private cache coherent with its peers on a snooping bus, using an update protocol that never invalidates a resident line. Every line is in one of three states: sole clean holder, sole modified holder, or one of several clean holders. Peers announce that they hold a copy by driving a wired-OR "copies present" line during the cycle of a bus transaction. That answer tells a requester whether it is the only holder. When a line is held by others, a processor write goes out on the bus as a write-through. Memory and every other copy take the new word in the same bus cycle.

The processor side is a valid/ready request channel with a one-cycle response strobe. The bus side is a request/grant pair carrying a command, an address and a word. Each controller also watches the transactions of the other controllers and answers them through the snoop inputs, the shared-line drive and a data-supply strobe. Each line holds one word, a tag and a state. A snooped bus write that hits a resident line is reported on a local update strobe. The controller also provides the write-back of a modified victim before it refills that line.

Top module: `coh_wt_update_ctrl`

## Requirements
- R1: After reset every line holds tag 0 and word 0 in the shared state (encoding 0), cpu_ready is high and bus_req is low; a read of any address with tag 0 hits and returns 0 without a bus transaction.
- R2: A request is taken in a cycle where cpu_valid and cpu_ready are both high. cpu_ready then stays low until the completing cycle, which raises cpu_rsp_valid for exactly one cycle. For a read, that cycle also carries cpu_rdata. The requester holds nothing after acceptance, and there is no back-pressure on the response.
- R3: A read hit completes in the cycle after acceptance without any bus request.
- R4: A read miss to a clean line issues a bus read (bus_cmd 0) and fills the line with bus_rdata. The line becomes shared if shr_in is high in the grant cycle and sole-clean (encoding 1) otherwise. The read completes three cycles after acceptance.
- R5: A write hit to a shared line issues a bus write (bus_cmd 1) with the address and word, and completes in the grant cycle. The line stays shared if shr_in is high and otherwise becomes sole-clean.
- R6: A write hit to a sole-clean line makes it modified (encoding 2) with no bus transaction. A write hit to a modified line also issues no bus transaction. Both complete in the cycle after acceptance.
- R7: A snooped bus read that hits a modified line raises sup_valid with the line word and drives shr_out in the same cycle. The line then becomes shared.
- R8: A snooped bus read that hits a sole-clean or shared line drives shr_out without sup_valid, and the line becomes shared.
- R9: A snooped bus write that hits a resident line replaces its word, raises upd_valid with the index and word, and drives shr_out. A snoop whose tag does not match leaves the line and its word untouched.
- R10: A miss whose victim is modified first issues a write-back (bus_cmd 2) of the victim tag, index and word. The victim then becomes sole-clean, and the refill follows.
- R11: A write miss allocates: the line is filled as in R4, after which the write proceeds as in R5 or R6.
- R12: A pending bus request keeps its command and address until granted. If a snoop hits the line it works on, the request is withdrawn and the lookup repeats.
- R13: shr_out and sup_valid are only asserted in cycles with snp_valid high and a tag match on a bus read or bus write; a snooped write-back is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request valid |
| cpu_ready | output | 1 | Controller can take a request |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | TAG_W+IDX_W | Word address {tag, index} |
| cpu_wdata | input | DATA_W | Write word |
| cpu_rsp_valid | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Read word, valid with cpu_rsp_valid |
| bus_req | output | 1 | Bus transaction requested |
| bus_gnt | input | 1 | Bus granted; transaction happens this cycle |
| bus_cmd | output | 2 | 0 read, 1 write, 2 write-back |
| bus_addr | output | TAG_W+IDX_W | Transaction address |
| bus_wdata | output | DATA_W | Word for write or write-back |
| bus_rdata | input | DATA_W | Fill word in the grant cycle of a read |
| shr_in | input | 1 | Wired-OR copies-present sense |
| snp_valid | input | 1 | Another controller's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command |
| snp_addr | input | TAG_W+IDX_W | Snooped address |
| snp_wdata | input | DATA_W | Snooped write word |
| shr_out | output | 1 | Drive of the copies-present line |
| sup_valid | output | 1 | Supplying a modified word for a snooped read |
| sup_data | output | DATA_W | Supplied word |
| upd_valid | output | 1 | Local word updated by a snooped write |
| upd_idx | output | IDX_W | Index of the updated line |
| upd_data | output | DATA_W | New word of that line |

## Verification
Two controllers share a modeled bus with memory. Directed sequences walk one line through every state transition, and each step is judged by which bus commands, supplies and updates it produced and by how many cycles it took. The same read can take one, three or five cycles. That latency separates a hit, a clean miss and a miss behind a modified victim. Whether a second write to the same line reaches the bus separates the sole-clean, modified and shared states, none of which is visible directly. A pseudo-random sweep of reads and writes, issued one at a time and then in concurrent pairs that share indices, compares every read against the last value written. This exposes any lost update, stale copy or dropped write-back, including those that appear only when a request is withdrawn.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    LS_SHARED = 2'd0,
    LS_SOLE   = 2'd1,
    LS_MOD    = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    BC_READ  = 2'd0,
    BC_WRITE = 2'd1,
    BC_WBACK = 2'd2
  } bus_cmd_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_LOOK = 2'd1,
    SQ_BUS  = 2'd2
  } seq_st_e;
endpackage

// File: rtl/coh_line_table.sv
module coh_line_table
  import coh_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16,
  localparam int LINES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  // port A: processor sequencer
  input  logic [IDX_W-1:0]  a_idx,
  output logic [TAG_W-1:0]  a_tag,
  output line_st_e          a_st,
  output logic [DATA_W-1:0] a_data,
  input  logic              a_we,
  input  logic [TAG_W-1:0]  a_wtag,
  input  line_st_e          a_wst,
  input  logic [DATA_W-1:0] a_wdata,
  // port B: snoop responder
  input  logic [IDX_W-1:0]  b_idx,
  output logic [TAG_W-1:0]  b_tag,
  output line_st_e          b_st,
  output logic [DATA_W-1:0] b_data,
  input  logic              b_we,
  input  line_st_e          b_wst,
  input  logic              b_wdata_en,
  input  logic [DATA_W-1:0] b_wdata
);
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];
  line_st_e          st_q   [LINES];

  assign a_tag  = tag_q[a_idx];
  assign a_st   = st_q[a_idx];
  assign a_data = data_q[a_idx];
  assign b_tag  = tag_q[b_idx];
  assign b_st   = st_q[b_idx];
  assign b_data = data_q[b_idx];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q[i]  <= '0;
        data_q[i] <= '0;
        st_q[i]   <= LS_SHARED;
      end else if (a_we && a_idx == IDX_W'(i)) begin
        tag_q[i]  <= a_wtag;
        data_q[i] <= a_wdata;
        st_q[i]   <= a_wst;
      end else if (b_we && b_idx == IDX_W'(i)) begin
        st_q[i] <= b_wst;
        if (b_wdata_en) data_q[i] <= b_wdata;
      end
    end
  end

  // R12: the sequencer must back off whenever a snoop touches its line
  assert_no_port_clash_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (a_we && b_we) |-> (a_idx != b_idx));
endmodule

// File: rtl/coh_snoop.sv
module coh_snoop
  import coh_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16,
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [DATA_W-1:0] snp_wdata,
  output logic [IDX_W-1:0]  line_idx,
  input  logic [TAG_W-1:0]  line_tag,
  input  line_st_e          line_st,
  input  logic [DATA_W-1:0] line_data,
  output logic              hit,
  output logic              shr_out,
  output logic              sup_valid,
  output logic [DATA_W-1:0] sup_data,
  output logic              tbl_we,
  output line_st_e          tbl_wst,
  output logic              tbl_wdata_en,
  output logic [DATA_W-1:0] tbl_wdata
);
  logic is_read, is_write;

  assign line_idx = snp_addr[IDX_W-1:0];
  assign is_read  = snp_cmd == 2'(BC_READ);
  assign is_write = snp_cmd == 2'(BC_WRITE);

  always_comb begin
    hit          = snp_valid && (is_read || is_write) &&
                   (line_tag == snp_addr[ADDR_W-1:IDX_W]);
    shr_out      = hit;
    sup_valid    = hit && is_read && (line_st == LS_MOD);
    sup_data     = line_data;
    tbl_we       = hit;
    tbl_wst      = LS_SHARED;
    tbl_wdata_en = hit && is_write;
    tbl_wdata    = snp_wdata;
  end
endmodule

// File: rtl/coh_cpu_seq.sv
module coh_cpu_seq
  import coh_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16,
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              shr_in,
  input  logic              snp_conflict,
  output logic [IDX_W-1:0]  line_idx,
  input  logic [TAG_W-1:0]  line_tag,
  input  line_st_e          line_st,
  input  logic [DATA_W-1:0] line_data,
  output logic              tbl_we,
  output logic [TAG_W-1:0]  tbl_wtag,
  output line_st_e          tbl_wst,
  output logic [DATA_W-1:0] tbl_wdata
);
  seq_st_e           st_q, st_d;
  logic              wr_q;
  logic [TAG_W-1:0]  tag_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] wd_q;
  bus_cmd_e          cmd_q, cmd_d;
  logic [ADDR_W-1:0] ba_q, ba_d;
  logic [DATA_W-1:0] bd_q, bd_d;
  logic              tag_hit;
  line_st_e          sensed_st;

  assign line_idx  = idx_q;
  assign tag_hit   = line_tag == tag_q;
  assign sensed_st = shr_in ? LS_SHARED : LS_SOLE;

  assign cpu_ready = st_q == SQ_IDLE;
  assign bus_req   = st_q == SQ_BUS;
  assign bus_cmd   = cmd_q;
  assign bus_addr  = ba_q;
  assign bus_wdata = bd_q;
  assign cpu_rdata = line_data;

  always_comb begin
    st_d          = st_q;
    cmd_d         = cmd_q;
    ba_d          = ba_q;
    bd_d          = bd_q;
    tbl_we        = 1'b0;
    tbl_wtag      = tag_q;
    tbl_wst       = LS_MOD;
    tbl_wdata     = wd_q;
    cpu_rsp_valid = 1'b0;
    unique case (st_q)
      SQ_IDLE: if (cpu_valid) st_d = SQ_LOOK;
      SQ_LOOK: begin
        if (!snp_conflict) begin
          if (tag_hit) begin
            if (!wr_q) begin
              cpu_rsp_valid = 1'b1;
              st_d          = SQ_IDLE;
            end else if (line_st == LS_SHARED) begin
              cmd_d = BC_WRITE;
              ba_d  = {tag_q, idx_q};
              bd_d  = wd_q;
              st_d  = SQ_BUS;
            end else begin
              tbl_we        = 1'b1;
              tbl_wst       = LS_MOD;
              cpu_rsp_valid = 1'b1;
              st_d          = SQ_IDLE;
            end
          end else if (line_st == LS_MOD) begin
            cmd_d = BC_WBACK;
            ba_d  = {line_tag, idx_q};
            bd_d  = line_data;
            st_d  = SQ_BUS;
          end else begin
            cmd_d = BC_READ;
            ba_d  = {tag_q, idx_q};
            st_d  = SQ_BUS;
          end
        end
      end
      SQ_BUS: begin
        if (bus_gnt) begin
          unique case (cmd_q)
            BC_READ: begin
              tbl_we    = 1'b1;
              tbl_wdata = bus_rdata;
              tbl_wst   = sensed_st;
              st_d      = SQ_LOOK;
            end
            BC_WRITE: begin
              tbl_we        = 1'b1;
              tbl_wst       = sensed_st;
              cpu_rsp_valid = 1'b1;
              st_d          = SQ_IDLE;
            end
            default: begin
              tbl_we    = 1'b1;
              tbl_wtag  = line_tag;
              tbl_wdata = line_data;
              tbl_wst   = LS_SOLE;
              st_d      = SQ_LOOK;
            end
          endcase
        end else if (snp_conflict) begin
          st_d = SQ_LOOK;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      wr_q  <= 1'b0;
      tag_q <= '0;
      idx_q <= '0;
      wd_q  <= '0;
      cmd_q <= BC_READ;
      ba_q  <= '0;
      bd_q  <= '0;
    end else begin
      st_q  <= st_d;
      cmd_q <= cmd_d;
      ba_q  <= ba_d;
      bd_q  <= bd_d;
      if (cpu_valid && cpu_ready) begin
        wr_q  <= cpu_write;
        tag_q <= cpu_addr[ADDR_W-1:IDX_W];
        idx_q <= cpu_addr[IDX_W-1:0];
        wd_q  <= cpu_wdata;
      end
    end
  end

  // R12: an ungranted request keeps its command and address unless withdrawn
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt && !snp_conflict) |=>
      (bus_req && $stable(bus_cmd) && $stable(bus_addr)));
  // R12: a grant only answers a request
  assert_gnt_has_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_gnt |-> bus_req);
  // R2: once a request is taken the controller is busy
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_ready) |=> !cpu_ready);
  // R2: a completion is a single-cycle strobe
  assert_rsp_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |=> !cpu_rsp_valid);
endmodule

// File: rtl/coh_wt_update_ctrl.sv
module coh_wt_update_ctrl
  import coh_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16,
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              shr_in,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [DATA_W-1:0] snp_wdata,
  output logic              shr_out,
  output logic              sup_valid,
  output logic [DATA_W-1:0] sup_data,
  output logic              upd_valid,
  output logic [IDX_W-1:0]  upd_idx,
  output logic [DATA_W-1:0] upd_data
);
  logic [IDX_W-1:0]  a_idx, b_idx;
  logic [TAG_W-1:0]  a_tag, b_tag, a_wtag;
  line_st_e          a_st, b_st, a_wst, b_wst;
  logic [DATA_W-1:0] a_data, b_data, a_wdata, b_wdata;
  logic              a_we, b_we, b_wdata_en;
  logic              snp_hit, snp_conflict;

  coh_line_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_table (
    .clk, .rst_n,
    .a_idx, .a_tag, .a_st, .a_data, .a_we, .a_wtag, .a_wst, .a_wdata,
    .b_idx, .b_tag, .b_st, .b_data, .b_we, .b_wst, .b_wdata_en, .b_wdata
  );

  coh_snoop #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .snp_valid, .snp_cmd, .snp_addr, .snp_wdata,
    .line_idx(b_idx), .line_tag(b_tag), .line_st(b_st), .line_data(b_data),
    .hit(snp_hit), .shr_out, .sup_valid, .sup_data,
    .tbl_we(b_we), .tbl_wst(b_wst), .tbl_wdata_en(b_wdata_en), .tbl_wdata(b_wdata)
  );

  assign snp_conflict = snp_hit && (b_idx == a_idx);

  coh_cpu_seq #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_seq (
    .clk, .rst_n,
    .cpu_valid, .cpu_ready, .cpu_write, .cpu_addr, .cpu_wdata,
    .cpu_rsp_valid, .cpu_rdata,
    .bus_req, .bus_gnt, .bus_cmd, .bus_addr, .bus_wdata, .bus_rdata, .shr_in,
    .snp_conflict,
    .line_idx(a_idx), .line_tag(a_tag), .line_st(a_st), .line_data(a_data),
    .tbl_we(a_we), .tbl_wtag(a_wtag), .tbl_wst(a_wst), .tbl_wdata(a_wdata)
  );

  assign upd_valid = b_wdata_en;
  assign upd_idx   = b_idx;
  assign upd_data  = b_wdata;

  // R13: the shared line is driven only in answer to a snooped transaction
  assert_shr_only_on_snoop_R13: assert property (@(posedge clk) disable iff (!rst_n)
    shr_out |-> (snp_valid && snp_cmd != 2'(BC_WBACK)));
  // R7: data is supplied only for a snooped read
  assert_supply_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sup_valid |-> (snp_valid && snp_cmd == 2'(BC_READ) && shr_out));
  // R7: after supplying, a snooped read of the same line asks for no supply again
  assert_supply_then_shared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sup_valid |=> !(sup_valid && snp_addr == $past(snp_addr)));
  // R9: a local update comes only from a snooped write
  assert_update_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (snp_valid && snp_cmd == 2'(BC_WRITE) && upd_data == snp_wdata));
  // R12: the bus never snoops a controller in its own grant cycle
  assert_no_self_snoop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_gnt && snp_valid));
endmodule

// File: tb/tb_coh_wt_update_ctrl.sv
`timescale 1ns/1ps
module tb_coh_wt_update_ctrl;
  localparam int N  = 2;
  localparam int IW = 2;
  localparam int TW = 2;
  localparam int DW = 8;
  localparam int AW = IW + TW;
  localparam int NA = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          c_valid [N];
  logic          c_write [N];
  logic [AW-1:0] c_addr  [N];
  logic [DW-1:0] c_wdata [N];
  logic          c_ready [N];
  logic          c_rsp   [N];
  logic [DW-1:0] c_rdata [N];
  logic          b_req   [N];
  logic          b_gnt   [N];
  logic [1:0]    b_cmd   [N];
  logic [AW-1:0] b_addr  [N];
  logic [DW-1:0] b_wdata [N];
  logic          s_valid [N];
  logic          s_shr   [N];
  logic          s_sup   [N];
  logic [DW-1:0] s_supd  [N];
  logic          u_valid [N];
  logic [IW-1:0] u_idx   [N];
  logic [DW-1:0] u_data  [N];

  logic [1:0]    g_cmd;
  logic [AW-1:0] g_addr;
  logic [DW-1:0] g_wdata, rdata, supd;
  logic          any_gnt, shr, sup_any;
  int            gsel;

  logic [DW-1:0] mem [NA] = '{default: '0};
  int cnt_rd = 0, cnt_wr = 0, cnt_wb = 0, cnt_sup = 0, bad_shr = 0;
  int cnt_upd [N] = '{default: 0};

  for (genvar g = 0; g < N; g++) begin : g_node
    coh_wt_update_ctrl #(.IDX_W(IW), .TAG_W(TW), .DATA_W(DW)) dut (
      .clk, .rst_n,
      .cpu_valid(c_valid[g]), .cpu_ready(c_ready[g]), .cpu_write(c_write[g]),
      .cpu_addr(c_addr[g]), .cpu_wdata(c_wdata[g]),
      .cpu_rsp_valid(c_rsp[g]), .cpu_rdata(c_rdata[g]),
      .bus_req(b_req[g]), .bus_gnt(b_gnt[g]), .bus_cmd(b_cmd[g]),
      .bus_addr(b_addr[g]), .bus_wdata(b_wdata[g]), .bus_rdata(rdata),
      .shr_in(shr),
      .snp_valid(s_valid[g]), .snp_cmd(g_cmd), .snp_addr(g_addr), .snp_wdata(g_wdata),
      .shr_out(s_shr[g]), .sup_valid(s_sup[g]), .sup_data(s_supd[g]),
      .upd_valid(u_valid[g]), .upd_idx(u_idx[g]), .upd_data(u_data[g])
    );
  end

  // bus model: lowest index wins, everyone else snoops
  always_comb begin
    any_gnt = 1'b0; gsel = 0;
    for (int i = N - 1; i >= 0; i--) if (b_req[i]) begin any_gnt = 1'b1; gsel = i; end
    g_cmd = b_cmd[gsel]; g_addr = b_addr[gsel]; g_wdata = b_wdata[gsel];
    shr = 1'b0; sup_any = 1'b0; supd = '0;
    for (int i = 0; i < N; i++) begin
      b_gnt[i]   = any_gnt && gsel == i;
      s_valid[i] = any_gnt && gsel != i;
      shr        = shr | s_shr[i];
      if (s_sup[i]) begin sup_any = 1'b1; supd = s_supd[i]; end
    end
    rdata = sup_any ? supd : mem[g_addr];
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (any_gnt) begin
        if (g_cmd == 2'd0) cnt_rd <= cnt_rd + 1;
        if (g_cmd == 2'd1) cnt_wr <= cnt_wr + 1;
        if (g_cmd == 2'd2) cnt_wb <= cnt_wb + 1;
        if (g_cmd != 2'd0) mem[g_addr] <= g_wdata;
      end
      if (sup_any) begin mem[g_addr] <= supd; cnt_sup <= cnt_sup + 1; end
      for (int i = 0; i < N; i++) begin
        if (u_valid[i]) cnt_upd[i] <= cnt_upd[i] + 1;
        if ((s_shr[i] || s_sup[i]) && !s_valid[i]) bad_shr <= bad_shr + 1;
      end
    end
  end

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] gold [NA] = '{default: '0};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic op(input int n, input bit wr, input logic [AW-1:0] a,
                    input logic [DW-1:0] d, output logic [DW-1:0] rd, output int lat);
    int t;
    @(negedge clk);
    while (!c_ready[n]) @(negedge clk);
    c_valid[n] = 1'b1; c_write[n] = wr; c_addr[n] = a; c_wdata[n] = d;
    @(negedge clk);
    c_valid[n] = 1'b0;
    lat = 1; t = 0;
    while (!c_rsp[n] && t < 200) begin @(negedge clk); lat++; t++; end
    rd = c_rdata[n];
    chk(c_rsp[n] && !c_ready[n], "R2 completion strobe", int'(c_rsp[n]), 1);
    if (wr) gold[a] = d;
  endtask

  task automatic rd_chk(input int n, input logic [AW-1:0] a, input string req, input int exp_lat);
    logic [DW-1:0] v; int l;
    op(n, 1'b0, a, '0, v, l);
    chk(v == gold[a], req, v, gold[a]);
    if (exp_lat > 0) chk(l == exp_lat, {req, " latency"}, l, exp_lat);
  endtask

  task automatic wr_chk(input int n, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input string req, input int exp_lat, input int exp_dwr);
    logic [DW-1:0] v; int l, w0;
    w0 = cnt_wr;
    op(n, 1'b1, a, d, v, l);
    @(negedge clk);
    chk(l == exp_lat, {req, " latency"}, l, exp_lat);
    chk(cnt_wr - w0 == exp_dwr, {req, " bus writes"}, cnt_wr - w0, exp_dwr);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  initial begin
    int r0, u0, s0, b0;
    logic [15:0] lf;
    for (int i = 0; i < N; i++) begin
      c_valid[i] = 1'b0; c_write[i] = 1'b0; c_addr[i] = '0; c_wdata[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    for (int i = 0; i < N; i++) begin
      chk(c_ready[i] == 1'b1, "R1 ready after reset", int'(c_ready[i]), 1);
      chk(b_req[i] == 1'b0, "R1 no bus request after reset", int'(b_req[i]), 0);
    end
    r0 = cnt_rd;
    rd_chk(0, 4'h0, "R1 R3 read hit after reset", 1);
    chk(cnt_rd == r0, "R3 read hit uses no bus", cnt_rd - r0, 0);

    // R5 R9: write to a line both hold
    u0 = cnt_upd[1];
    wr_chk(0, 4'h0, 8'h11, "R5 shared write", 2, 1);
    chk(cnt_upd[1] - u0 == 1, "R9 peer word update", cnt_upd[1] - u0, 1);
    wr_chk(0, 4'h0, 8'h12, "R5 stays shared with copies", 2, 1);
    rd_chk(1, 4'h0, "R9 peer reads updated word", 1);

    // R4 R6: sole holder, then modified
    r0 = cnt_rd; u0 = cnt_upd[1];
    rd_chk(0, 4'h5, "R4 read miss", 3);
    chk(cnt_rd - r0 == 1, "R4 one bus read", cnt_rd - r0, 1);
    rd_chk(1, 4'h1, "R9 tag-mismatch snoop leaves line", 1);
    chk(cnt_upd[1] == u0, "R9 no update on mismatch", cnt_upd[1] - u0, 0);
    wr_chk(0, 4'h5, 8'h21, "R6 sole-clean write local", 1, 0);
    wr_chk(0, 4'h5, 8'h22, "R6 modified write local", 1, 0);
    chk(mem[5] == 8'h00, "R6 memory not written", mem[5], 0);

    // R7: snooped read of a modified line
    s0 = cnt_sup;
    rd_chk(1, 4'h5, "R7 supplied word", 3);
    chk(cnt_sup - s0 == 1, "R7 one supply", cnt_sup - s0, 1);
    chk(mem[5] == 8'h22, "R7 memory takes supplied word", mem[5], 8'h22);
    wr_chk(0, 4'h5, 8'h23, "R7 supplier now shared", 2, 1);
    rd_chk(1, 4'h5, "R9 update after supply", 1);

    // R10 R11: write miss allocates, then modified victim written back
    r0 = cnt_rd;
    wr_chk(0, 4'hA, 8'h31, "R11 write miss to sole line", 3, 0);
    chk(cnt_rd - r0 == 1, "R11 fill read", cnt_rd - r0, 1);
    b0 = cnt_wb;
    rd_chk(0, 4'hE, "R10 miss behind modified victim", 5);
    chk(cnt_wb - b0 == 1, "R10 one write-back", cnt_wb - b0, 1);
    chk(mem[10] == 8'h31, "R10 victim word in memory", mem[10], 8'h31);

    // R8: snooped read of a sole-clean line
    s0 = cnt_sup;
    rd_chk(1, 4'hE, "R8 read of sole-clean line", 3);
    chk(cnt_sup == s0, "R8 no supply from clean", cnt_sup - s0, 0);
    wr_chk(0, 4'hE, 8'h51, "R8 holder now shared", 2, 1);

    // R5: copies gone -> write-through leaves line sole-clean
    rd_chk(1, 4'hD, "R5 peer evicts shared copy", 3);
    wr_chk(0, 4'h5, 8'h41, "R5 write with no copies", 2, 1);
    wr_chk(0, 4'h5, 8'h42, "R5 line became sole-clean", 1, 0);
    chk(bad_shr == 0, "R13 drive only on snoop", bad_shr, 0);

    // sweep: sequential
    lf = 16'hACE1;
    for (int k = 0; k < 300; k++) begin
      logic [DW-1:0] v; int l;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      op(int'(lf[0]), lf[1], lf[5:2], lf[15:8], v, l);
      if (!lf[1]) chk(v == gold[lf[5:2]], "R4 R9 R10 sweep read", v, gold[lf[5:2]]);
    end
    // sweep: concurrent pairs on distinct addresses
    for (int k = 0; k < 150; k++) begin
      logic [AW-1:0] a0, a1; logic w0, w1; logic [DW-1:0] d0, d1, e0, e1, v0, v1; int l0, l1;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      a0 = lf[3:0]; a1 = {lf[7:6], lf[1:0]};
      if (a1 == a0) a1 = a0 ^ 4'h4;
      w0 = lf[8]; w1 = lf[9]; d0 = lf[15:8]; d1 = ~lf[15:8];
      e0 = gold[a0]; e1 = gold[a1];
      fork
        op(0, w0, a0, d0, v0, l0);
        op(1, w1, a1, d1, v1, l1);
      join
      if (!w0) chk(v0 == e0, "R12 concurrent read node0", v0, e0);
      if (!w1) chk(v1 == e1, "R12 concurrent read node1", v1, e1);
    end
    for (int a = 0; a < NA; a++) begin
      rd_chk(a % 2, AW'(a), "R12 final coherence", 0);
      rd_chk((a + 1) % 2, AW'(a), "R12 final coherence", 0);
    end
    chk(bad_shr == 0, "R13 drive only on snoop", bad_shr, 0);
    summary();
  end
endmodule